// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. It also holds the interrupt message number. It turns slot events into interrupt notifications. Software reaches the block through a simple register bus with word addresses and byte enables. Side inputs report a card insertion request and a removal (attention-button) request. The block answers with a level interrupt line, a one-cycle message request that carries a vector number, a detach request toward the secondary side, and an error pulse when an insertion is refused.

The enabled and supported event bits are combined into one pending condition. A notification is sent only when that condition rises. In message mode the notification is a pulse. In level mode the line follows the condition. Every write to the control register is one command and reports command completion. A write-only control bit toggles an emulated electromechanical interlock. While the interlock is engaged, insertions are refused.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Word address 0 holds the interrupt message number in bits [4:0], address 1 holds slot control, address 2 holds slot status, and address 3 reads 0. Read data appears on `bus_rdata` one cycle after the read and holds until the next read. Control bit 9 (interlock toggle) always reads 0.
- R2: pending = ctrl[3] (interrupt enable) AND any of status[2:0] AND ctrl[2:0]. Bit 0 is attention-button, bit 1 is presence-changed and bit 2 is command-completed, each paired with its enable. When `msg_en` is 1, a rise of pending gives one `msg_req` pulse two cycles after the event, with `msg_vec` equal to the message number. Setting an event bit that is already set gives no new pulse.
- R3: `irq_level` equals pending while `msg_en` is 0 and is 0 while `msg_en` is 1. It is registered, so it follows a state change by one cycle.
- R4: A write that enables any byte of the control register sets status bit 2 (command completed).
- R5: A control write with bit 9 = 1 in an enabled byte toggles status bit 4 (interlock engaged).
- R6: Status bits [2:0] are write-one-to-clear. Status bits 3 (presence detected) and 4 (interlock) ignore status writes. Clearing the last enabled pending event drops `irq_level`.
- R7: While status bit 4 is set, `insert_req` pulses `insert_err` and changes nothing. Otherwise it sets status bits 3, 1 and 0. `remove_req` sets only status bit 0.
- R8: A control write that leaves power control (ctrl bit 8) at 1 and power indicator ctrl[7:6] at 11 (off) while status bit 3 is set pulses `detach_req`, clears status bit 3 and sets status bit 1.
- R9: After reset, all enables and the interrupt enable are 0, the attention indicator ctrl[5:4] is 11 (off), the interlock is released, and the message number is 0. The power indicator is 01 (on) with status bit 3 set when `present_at_reset` is 1, else 11 (off) with status bit 3 clear. Indicator codes are 01 on, 10 blink, 11 off.
- R10: Only bytes whose `bus_be` bit is set are written. Byte 0 is bits [7:0] and byte 1 is bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| present_at_reset | input | 1 | Slot occupied when reset is applied |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables |
| bus_rdata | output | 16 | Registered read data |
| msg_en | input | 1 | Message interrupt mode selected |
| insert_req | input | 1 | Card insertion request pulse |
| remove_req | input | 1 | Removal / attention-button request pulse |
| insert_err | output | 1 | Insertion refused (interlock engaged) |
| irq_level | output | 1 | Level interrupt line |
| msg_req | output | 1 | Message interrupt request pulse |
| msg_vec | output | VEC_W | Vector carried by the message request |
| detach_req | output | 1 | Request to detach the card |

## Verification
The bench builds the block with ADDR_W = 2 and VEC_W = 5. With ADDR_W = 2 every address is reachable, including the unmapped fourth word. With VEC_W = 5 a full five-bit vector (0x15) can be carried on `msg_vec`. It can also be shown that upper-byte writes to the message number register are dropped. Both reset flavours are run: an empty slot and an occupied slot. The occupied case reaches the detach path. The interlock is toggled with split byte enables.

// File: rtl/hp_pkg.sv
package hp_pkg;
  parameter int REG_W = 16;
  localparam int BE_W = REG_W / 8;

  // control field positions
  localparam int C_ABP_EN  = 0;
  localparam int C_PDC_EN  = 1;
  localparam int C_CC_EN   = 2;
  localparam int C_HPIE    = 3;
  localparam int C_ATTN_LO = 4;
  localparam int C_PIND_LO = 6;
  localparam int C_PCTL    = 8;
  localparam int C_ILK     = 9;

  // status field positions
  localparam int S_ABP = 0;
  localparam int S_PDC = 1;
  localparam int S_CC  = 2;
  localparam int S_PDS = 3;
  localparam int S_ILS = 4;
  localparam int EV_N  = 3;

  localparam logic [REG_W-1:0] CTRL_WMASK = REG_W'(16'h01FF);
  localparam logic [REG_W-1:0] STAT_W1C   = REG_W'((1 << EV_N) - 1);

  localparam int A_CAPS = 0;
  localparam int A_CTRL = 1;
  localparam int A_STAT = 2;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_t;
endpackage

// File: rtl/hp_bus_dec.sv
module hp_bus_dec
  import hp_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  output logic              wr_caps,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              rd_en,
  output logic [REG_W-1:0]  bmask
);
  logic wr;
  assign wr      = bus_valid && bus_write;
  assign wr_caps = wr && (bus_addr == ADDR_W'(A_CAPS));
  assign wr_ctrl = wr && (bus_addr == ADDR_W'(A_CTRL)) && (|bus_be);
  assign wr_stat = wr && (bus_addr == ADDR_W'(A_STAT));
  assign rd_en   = bus_valid && !bus_write;

  for (genvar g = 0; g < BE_W; g++) begin : g_mask
    assign bmask[g*8 +: 8] = {8{bus_be[g]}};
  end
endmodule

// File: rtl/hp_slot_state.sv
module hp_slot_state
  import hp_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             present_at_reset,
  input  logic             wr_caps,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] bmask,
  input  logic             insert_req,
  input  logic             remove_req,
  output logic [REG_W-1:0] caps_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] sts_q,
  output logic             detach_req,
  output logic             insert_err
);
  localparam logic [REG_W-1:0] CAPS_MASK = REG_W'((1 << VEC_W) - 1);

  logic [REG_W-1:0] wd, caps_n, ctrl_n, sts_n;
  logic             det_n, err_n;

  always_comb begin
    wd     = wdata & bmask;
    caps_n = caps_q;
    ctrl_n = ctrl_q;
    sts_n  = sts_q;
    det_n  = 1'b0;
    err_n  = 1'b0;
    if (wr_caps) caps_n = ((caps_q & ~bmask) | wd) & CAPS_MASK;
    if (wr_stat) sts_n = sts_q & ~(wd & STAT_W1C);
    if (wr_ctrl) begin
      if (wd[C_ILK]) sts_n[S_ILS] = ~sts_q[S_ILS];
      ctrl_n = ((ctrl_q & ~bmask) | wd) & CTRL_WMASK;
      if (sts_q[S_PDS] && ctrl_n[C_PCTL] &&
          (ctrl_n[C_PIND_LO +: 2] == IND_OFF)) begin
        det_n        = 1'b1;
        sts_n[S_PDS] = 1'b0;
        sts_n[S_PDC] = 1'b1;
      end
      sts_n[S_CC] = 1'b1;
    end
    if (insert_req) begin
      if (sts_q[S_ILS]) begin
        err_n = 1'b1;
      end else begin
        sts_n[S_PDS] = 1'b1;
        sts_n[S_PDC] = 1'b1;
        sts_n[S_ABP] = 1'b1;
      end
    end
    if (remove_req) sts_n[S_ABP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      caps_q                   <= '0;
      ctrl_q                   <= '0;
      ctrl_q[C_ATTN_LO +: 2]   <= IND_OFF;
      ctrl_q[C_PIND_LO +: 2]   <= present_at_reset ? IND_ON : IND_OFF;
      sts_q                    <= '0;
      sts_q[S_PDS]             <= present_at_reset;
      detach_req               <= 1'b0;
      insert_err               <= 1'b0;
    end else begin
      caps_q     <= caps_n;
      ctrl_q     <= ctrl_n;
      sts_q      <= sts_n;
      detach_req <= det_n;
      insert_err <= err_n;
    end
  end
endmodule

// File: rtl/hp_notify.sv
module hp_notify
  import hp_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_en,
  input  logic             hpie,
  input  logic [EV_N-1:0]  ev_en,
  input  logic [EV_N-1:0]  ev_sts,
  input  logic [VEC_W-1:0] vec,
  output logic             irq_level,
  output logic             msg_req,
  output logic [VEC_W-1:0] msg_vec
);
  logic pend, pend_q, rise;

  assign pend = hpie && (|(ev_en & ev_sts));
  assign rise = pend && !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      irq_level <= 1'b0;
      msg_req   <= 1'b0;
      msg_vec   <= '0;
    end else begin
      pend_q    <= pend;
      irq_level <= pend && !msg_en;
      msg_req   <= rise && msg_en;
      msg_vec   <= (rise && msg_en) ? vec : '0;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int VEC_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              present_at_reset,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [1:0]        bus_be,
  output logic [15:0]       bus_rdata,
  input  logic              msg_en,
  input  logic              insert_req,
  input  logic              remove_req,
  output logic              insert_err,
  output logic              irq_level,
  output logic              msg_req,
  output logic [VEC_W-1:0]  msg_vec,
  output logic              detach_req
);
  logic             wr_caps, wr_ctrl, wr_stat, rd_en;
  logic [REG_W-1:0] bmask, caps_q, ctrl_q, sts_q;

  hp_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .wr_caps(wr_caps), .wr_ctrl(wr_ctrl),
    .wr_stat(wr_stat), .rd_en(rd_en), .bmask(bmask)
  );

  hp_slot_state #(.VEC_W(VEC_W)) u_state (
    .clk(clk), .rst(rst), .present_at_reset(present_at_reset),
    .wr_caps(wr_caps), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdata(bus_wdata), .bmask(bmask),
    .insert_req(insert_req), .remove_req(remove_req),
    .caps_q(caps_q), .ctrl_q(ctrl_q), .sts_q(sts_q),
    .detach_req(detach_req), .insert_err(insert_err)
  );

  hp_notify #(.VEC_W(VEC_W)) u_notify (
    .clk(clk), .rst(rst), .msg_en(msg_en),
    .hpie(ctrl_q[C_HPIE]),
    .ev_en(ctrl_q[C_CC_EN:C_ABP_EN]),
    .ev_sts(sts_q[S_CC:S_ABP]),
    .vec(caps_q[VEC_W-1:0]),
    .irq_level(irq_level), .msg_req(msg_req), .msg_vec(msg_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        ADDR_W'(A_CAPS): bus_rdata <= caps_q;
        ADDR_W'(A_CTRL): bus_rdata <= ctrl_q;
        ADDR_W'(A_STAT): bus_rdata <= sts_q;
        default:         bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
  parameter int ADDR_W = 2,
  parameter int VEC_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_rdata,
  input logic              msg_en,
  input logic              insert_req,
  input logic              insert_err,
  input logic              irq_level,
  input logic              msg_req,
  input logic [VEC_W-1:0]  msg_vec,
  input logic              detach_req
);
  // R2: a message pulse only follows a cycle in message mode
  a_r2_msg_needs_mode: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> $past(msg_en));

  // R2: a rising edge cannot repeat on the next cycle
  a_r2_msg_isolated: assert property (@(posedge clk) disable iff (rst)
    msg_req |=> !msg_req);

  // R2: vector is idle outside a pulse
  a_r2_vec_idle: assert property (@(posedge clk) disable iff (rst)
    !msg_req |-> (msg_vec == '0));

  // R3: level line silent after a cycle in message mode
  a_r3_level_off_in_msg_mode: assert property (@(posedge clk) disable iff (rst)
    irq_level |-> !$past(msg_en));

  // R8: detach only follows a control write
  a_r8_detach_from_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    detach_req |-> $past(bus_valid && bus_write && (bus_addr == ADDR_W'(1))));

  // R7: refusal only follows an insertion request
  a_r7_err_from_insert: assert property (@(posedge clk) disable iff (rst)
    insert_err |-> $past(insert_req));

  // R1: read data holds when no read was issued
  a_r1_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_valid && !bus_write)) |-> $stable(bus_rdata));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .msg_en(msg_en),
  .insert_req(insert_req), .insert_err(insert_err), .irq_level(irq_level),
  .msg_req(msg_req), .msg_vec(msg_vec), .detach_req(detach_req)
);

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;
  localparam int ADDR_W = 2;
  localparam int VEC_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              present_at_reset = 1'b0;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0]       bus_wdata = '0;
  logic [1:0]        bus_be = '0;
  logic [15:0]       bus_rdata;
  logic              msg_en = 1'b0, insert_req = 1'b0, remove_req = 1'b0;
  logic              insert_err, irq_level, msg_req, detach_req;
  logic [VEC_W-1:0]  msg_vec;

  always #10 clk = ~clk;

  hp_slot_ctrl #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_hp_slot_ctrl (
    .clk(clk), .rst(rst), .present_at_reset(present_at_reset),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .msg_en(msg_en), .insert_req(insert_req), .remove_req(remove_req),
    .insert_err(insert_err), .irq_level(irq_level), .msg_req(msg_req),
    .msg_vec(msg_vec), .detach_req(detach_req)
  );

  int n_chk = 0, n_fail = 0;
  int msg_cnt = 0, det_cnt = 0, err_cnt = 0;
  logic [VEC_W-1:0] last_vec = '0;
  bit done = 0, seen_edge = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference state
  bit m_abp_en, m_pdc_en, m_cc_en, m_hpie, m_pctl;
  bit [1:0] m_attn, m_pind;
  bit m_abp, m_pdc, m_cc, m_pds, m_ils, m_prev;
  bit [15:0] m_caps;
  logic e_irq = 0, e_msg = 0, e_det = 0, e_err = 0;
  logic [15:0] e_rdata = 0;
  logic [VEC_W-1:0] e_vec = 0;

  function automatic bit [15:0] ctrl_word();
    return {7'd0, m_pctl, m_pind, m_attn, m_hpie, m_cc_en, m_pdc_en, m_abp_en};
  endfunction
  function automatic bit [15:0] stat_word();
    return {11'd0, m_ils, m_pds, m_cc, m_pdc, m_abp};
  endfunction

  always @(posedge clk) begin
    seen_edge = 1;
    if (rst) begin
      {m_abp_en, m_pdc_en, m_cc_en, m_hpie, m_pctl} = '0;
      m_attn = 2'b11;
      m_pind = present_at_reset ? 2'b01 : 2'b11;
      {m_abp, m_pdc, m_cc, m_ils, m_prev} = '0;
      m_pds = present_at_reset;
      m_caps = 0;
      e_irq = 0; e_msg = 0; e_det = 0; e_err = 0; e_rdata = 0; e_vec = 0;
    end else begin
      bit pend, ils_old;
      bit [15:0] mask, d, nc;
      pend = m_hpie && ((m_abp && m_abp_en) || (m_pdc && m_pdc_en) || (m_cc && m_cc_en));
      e_irq = pend && !msg_en;
      e_msg = pend && !m_prev && msg_en;
      e_vec = e_msg ? m_caps[VEC_W-1:0] : '0;
      m_prev = pend;
      ils_old = m_ils;
      e_det = 0; e_err = 0;
      if (bus_valid && !bus_write) begin
        case (bus_addr)
          2'd0: e_rdata = m_caps;
          2'd1: e_rdata = ctrl_word();
          2'd2: e_rdata = stat_word();
          default: e_rdata = 0;
        endcase
      end
      if (bus_valid && bus_write) begin
        mask = {{8{bus_be[1]}}, {8{bus_be[0]}}};
        d = bus_wdata & mask;
        if (bus_addr == 2'd0) m_caps = ((m_caps & ~mask) | d) & 16'h001F;
        if (bus_addr == 2'd2) begin
          if (d[0]) m_abp = 0;
          if (d[1]) m_pdc = 0;
          if (d[2]) m_cc = 0;
        end
        if (bus_addr == 2'd1 && bus_be != 2'b00) begin
          if (d[9]) m_ils = !m_ils;
          nc = (ctrl_word() & ~mask) | d;
          {m_pctl, m_pind, m_attn, m_hpie, m_cc_en, m_pdc_en, m_abp_en} = nc[8:0];
          if (m_pds && m_pctl && m_pind == 2'b11) begin
            e_det = 1; m_pds = 0; m_pdc = 1;
          end
          m_cc = 1;
        end
      end
      if (insert_req) begin
        if (ils_old) e_err = 1;
        else begin m_pds = 1; m_pdc = 1; m_abp = 1; end
      end
      if (remove_req) m_abp = 1;
    end
  end

  // per-cycle comparison against the reference, away from the edge
  always @(negedge clk) begin
    if (seen_edge && !done) begin
      check("R3 irq_level", irq_level, e_irq);
      check("R2 msg_req", msg_req, e_msg);
      check("R2 msg_vec", msg_vec, e_vec);
      check("R8 detach_req", detach_req, e_det);
      check("R7 insert_err", insert_err, e_err);
      check("R1 bus_rdata", bus_rdata, e_rdata);
      if (msg_req) begin msg_cnt++; last_vec = msg_vec; end
      if (detach_req) det_cnt++;
      if (insert_err) err_cnt++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    v = bus_rdata;
  endtask

  task automatic pulse_insert();
    @(negedge clk); insert_req = 1;
    @(negedge clk); insert_req = 0;
  endtask

  task automatic pulse_remove();
    @(negedge clk); remove_req = 1;
    @(negedge clk); remove_req = 0;
  endtask

  task automatic do_reset(input logic p);
    @(negedge clk); rst = 1; present_at_reset = p;
    idle(2);
    rst = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    do_reset(1'b0);
    // R9: empty-slot reset values
    rd(2'd1, v); check("R9 ctrl after empty reset", v, 16'h00F0);
    rd(2'd2, v); check("R9 status after empty reset", v, 16'h0000);
    rd(2'd0, v); check("R9 message number after reset", v, 16'h0000);
    check("R3 no irq after reset", irq_level, 1'b0);

    // R1 / R10: message number register and byte enables
    wr(2'd0, 16'h0015, 2'b01);
    rd(2'd0, v); check("R1 message number readback", v, 16'h0015);
    wr(2'd0, 16'hFF1F, 2'b10);
    rd(2'd0, v); check("R10 upper-byte write leaves vector", v, 16'h0015);
    rd(2'd3, v); check("R1 unmapped word reads 0", v, 16'h0000);

    // R4: control write completes a command
    wr(2'd1, 16'h00FB, 2'b11);
    rd(2'd2, v); check("R4 command completed set", v, 16'h0004);
    check("R2 cc not enabled so no irq", irq_level, 1'b0);

    // R7 / R3: removal sets attention only, level line rises
    pulse_remove(); idle(2);
    rd(2'd2, v); check("R7 removal sets only attention", v, 16'h0005);
    check("R3 level line follows pending", irq_level, 1'b1);

    // R6: write-one-to-clear drops the level line
    wr(2'd2, 16'h0001, 2'b01); idle(2);
    rd(2'd2, v); check("R6 attention cleared", v, 16'h0004);
    check("R6 level line dropped", irq_level, 1'b0);

    // R2: message mode, insertion raises pending once
    msg_en = 1;
    pulse_insert(); idle(3);
    check("R2 one message pulse", msg_cnt, 1);
    check("R2 message vector", last_vec, 5'h15);
    check("R3 level line silent in message mode", irq_level, 1'b0);
    rd(2'd2, v); check("R7 insertion sets presence bits", v, 16'h000F);
    pulse_remove(); idle(3);
    check("R2 already-set event gives no pulse", msg_cnt, 1);

    // R5: interlock toggle, control bit reads 0
    wr(2'd1, 16'h02FB, 2'b11);
    rd(2'd1, v); check("R5 toggle bit reads 0", v, 16'h00FB);
    rd(2'd2, v); check("R5 interlock engaged", v, 16'h001F);
    wr(2'd2, 16'h0018, 2'b01);
    rd(2'd2, v); check("R6 presence and interlock ignore status writes", v, 16'h001F);

    // R7: refused insertion
    pulse_insert(); idle(2);
    check("R7 insertion refused", err_cnt, 1);
    rd(2'd2, v); check("R7 refused insertion changes nothing", v, 16'h001F);

    // R10 / R5: toggle bit in a disabled byte is ignored
    wr(2'd1, 16'h02FB, 2'b01);
    rd(2'd2, v); check("R10 toggle in disabled byte ignored", v, 16'h001F);
    wr(2'd1, 16'h0200, 2'b10);
    rd(2'd2, v); check("R5 interlock released", v, 16'h000F);
    rd(2'd1, v); check("R10 low byte kept", v, 16'h00FB);

    // R8: detach when power off and indicator off
    wr(2'd1, 16'h01FB, 2'b11); idle(1);
    check("R8 detach requested", det_cnt, 1);
    rd(2'd2, v); check("R8 presence cleared, change set", v, 16'h0007);
    wr(2'd1, 16'h01FB, 2'b11); idle(1);
    check("R8 no detach on empty slot", det_cnt, 1);

    wr(2'd2, 16'h0007, 2'b01); idle(2);
    rd(2'd2, v); check("R6 all events cleared", v, 16'h0000);

    // R9: occupied-slot reset
    msg_en = 0;
    do_reset(1'b1);
    rd(2'd1, v); check("R9 ctrl after occupied reset", v, 16'h0070);
    rd(2'd2, v); check("R9 presence after occupied reset", v, 16'h0008);
    rd(2'd0, v); check("R9 vector cleared", v, 16'h0000);
    wr(2'd1, 16'h01F0, 2'b11); idle(1);
    check("R8 detach after occupied reset", det_cnt, 2);
    idle(3);
    finish_run();
  end
endmodule